// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers 96 interrupt lines into three banks of 32 and presents them to a processor as two request wires: a normal request and a fast request. Each line has its own enable, mask, route-select and 2-bit priority. A line that is enabled and asserted is captured in a sticky pending bit. Software clears that bit by writing a one to it.

Among the pending lines that are enabled, unmasked and routed to the normal request, the block picks the one with the highest priority. It reports that line through a vector register as a base address plus the line number times four. Line 0 is reserved: it never drives a request and is never reported, so a vector offset of zero means that nothing is waiting.

Software reaches every register over a plain 32-bit write port and a combinational read port. The bank of a line is its number divided by 32, and its bit within the bank is the number modulo 32.

Top module: `intc_banked_top`

## Requirements
- R1: After reset all enable, mask, select, priority and pending bits and the base register are zero, `irq_o` and `fiq_o` are low, and the vector register at offset 0x00 reads 0.
- R2: While its enable bit is 1, an asserted line n sets the pending bit in bank n/32, bit n%32. The normal pending word of bank b at offset 0x10+4b shows the pending lines whose select bit is 0. The fast pending word at 0x20+4b shows those whose select bit is 1.
- R3: Offset 0x00 reads the base register plus the index of the winning line shifted left by 2. With no winner it reads the base alone. Line 0 is never reported and never raises an output.
- R4: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A line whose enable bit (offset 0x40+4b) is 0 never sets its pending bit. A bit that is already pending stays set when the line is disabled.
- R6: A mask bit of 1 (offset 0x50+4b) keeps its line off `irq_o`, `fiq_o` and the vector while the pending bit stays readable. Clearing the mask lets the line through.
- R7: The priority of line n is the 2-bit field at bits [2*(n%16)+1 : 2*(n%16)] of the word at offset 0x80+4*(n/16). Value 3 is the highest and 0 the lowest. On equal priority the lower line number wins.
- R8: A select bit of 1 (offset 0x30+4b) routes its line to `fiq_o` and not to `irq_o`. A select bit of 0 routes it to `irq_o`.
- R9: A line still asserted in the cycle its pending bit is cleared reads as pending afterwards.
- R10: The pending bit is visible one clock edge after the line is sampled. `irq_o`, `fiq_o` and the vector follow one edge after the pending, enable, mask, select or priority state they depend on.
- R11: The base register at offset 0x04 is readable and writable.
- R12: The enable, mask, select and priority words read back what was written. Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Interrupt lines, one per source |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A line driven before a rising edge shows in its pending word right after that edge, and the request outputs and the vector show it one edge later. Register writes follow the same pattern: stored state changes at the write edge and the outputs derived from it change one edge after. The bench drives on falling edges and samples half a period later, counting edges explicitly. For the timing requirement it checks that the request is still low after the first edge and high after the second. After every write that changes priority, mask or routing, it waits one more edge before reading the vector or the outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_SRC      = 96;
    localparam int BANK_W       = 32;
    localparam int NUM_BANK     = NUM_SRC / BANK_W;
    localparam int PRIO_W       = 2;
    localparam int PRIO_PER_REG = BANK_W / PRIO_W;
    localparam int NUM_PRIO_REG = NUM_SRC / PRIO_PER_REG;
    localparam int IDX_W        = $clog2(NUM_SRC);
    localparam int ADDR_W       = 8;

    localparam logic [ADDR_W-1:0] OFF_VECTOR = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_BASE   = 8'h04;
    localparam logic [3:0] GRP_IRQ_PEND = 4'h1;
    localparam logic [3:0] GRP_FIQ_PEND = 4'h2;
    localparam logic [3:0] GRP_SELECT   = 4'h3;
    localparam logic [3:0] GRP_ENABLE   = 4'h4;
    localparam logic [3:0] GRP_MASK     = 4'h5;
    localparam logic [2:0] GRP_PRIO_HI  = 3'b100;

    typedef struct packed {
        logic [BANK_W-1:0]         base;
        logic [NUM_SRC-1:0]        pend;
        logic [NUM_SRC-1:0]        en;
        logic [NUM_SRC-1:0]        mask;
        logic [NUM_SRC-1:0]        sel;
        logic [PRIO_W*NUM_SRC-1:0] prio;
        logic                      irq;
        logic                      fiq;
        logic [IDX_W-1:0]          vec_idx;
    } intc_state_t;
endpackage

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
    parameter int W = 32
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] sel_i,
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] irq_clr_i,
    input  logic [W-1:0] fiq_clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] clr;

    always_comb begin
        // a clear only reaches bits that are visible in the word written
        clr    = (irq_clr_i & ~sel_i) | (fiq_clr_i & sel_i);
        // a live, enabled line wins over a clear in the same cycle
        pend_o = (pend_i & ~clr) | (src_i & en_i);
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N  = 96,
    parameter int PW = 2,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]    req_i,
    input  logic [PW*N-1:0] prio_i,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o
);
    logic [PW-1:0] best_lvl;

    always_comb begin
        valid_o  = 1'b0;
        idx_o    = '0;
        best_lvl = '0;
        // strict compare keeps the lowest index among equal levels
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!valid_o || prio_i[PW*i +: PW] > best_lvl)) begin
                valid_o  = 1'b1;
                best_lvl = prio_i[PW*i +: PW];
                idx_o    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_banked_top.sv
module intc_banked_top
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [BANK_W-1:0]   bus_wdata_i,
    output logic [BANK_W-1:0]   bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);
    localparam logic [NUM_SRC-1:0] SRC0_OFF = ~NUM_SRC'(1);

    intc_state_t st_q, st_d;

    logic [NUM_SRC-1:0] irq_clr, fiq_clr, pend_next;
    logic [NUM_SRC-1:0] irq_req, fiq_req;
    logic               irq_any;
    logic [IDX_W-1:0]   irq_idx;
    logic               wr_ok;
    logic [3:0]         grp;
    logic [1:0]         bank_sel;
    logic [2:0]         prio_sel;
    logic               is_prio;

    assign wr_ok    = bus_we_i && (bus_addr_i[1:0] == 2'b00);
    assign grp      = bus_addr_i[7:4];
    assign bank_sel = bus_addr_i[3:2];
    assign prio_sel = bus_addr_i[4:2];
    assign is_prio  = (bus_addr_i[7:5] == GRP_PRIO_HI);

    always_comb begin
        irq_clr = '0;
        fiq_clr = '0;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (wr_ok && bank_sel == 2'(b)) begin
                if (grp == GRP_IRQ_PEND) irq_clr[b*BANK_W +: BANK_W] = bus_wdata_i;
                if (grp == GRP_FIQ_PEND) fiq_clr[b*BANK_W +: BANK_W] = bus_wdata_i;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        intc_pend_bank #(.W(BANK_W)) u_bank (
            .src_i     (src_i  [b*BANK_W +: BANK_W]),
            .en_i      (st_q.en [b*BANK_W +: BANK_W]),
            .sel_i     (st_q.sel[b*BANK_W +: BANK_W]),
            .pend_i    (st_q.pend[b*BANK_W +: BANK_W]),
            .irq_clr_i (irq_clr[b*BANK_W +: BANK_W]),
            .fiq_clr_i (fiq_clr[b*BANK_W +: BANK_W]),
            .pend_o    (pend_next[b*BANK_W +: BANK_W])
        );
    end

    assign irq_req = st_q.pend & st_q.en & ~st_q.mask & ~st_q.sel & SRC0_OFF;
    assign fiq_req = st_q.pend & st_q.en & ~st_q.mask &  st_q.sel & SRC0_OFF;

    intc_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_arb (
        .req_i   (irq_req),
        .prio_i  (st_q.prio),
        .valid_o (irq_any),
        .idx_o   (irq_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pend    = pend_next;
        st_d.irq     = irq_any;
        st_d.fiq     = |fiq_req;
        st_d.vec_idx = irq_any ? irq_idx : '0;
        if (wr_ok) begin
            if (bus_addr_i == OFF_BASE) st_d.base = bus_wdata_i;
            for (int b = 0; b < NUM_BANK; b++) begin
                if (bank_sel == 2'(b)) begin
                    if (grp == GRP_SELECT) st_d.sel [b*BANK_W +: BANK_W] = bus_wdata_i;
                    if (grp == GRP_ENABLE) st_d.en  [b*BANK_W +: BANK_W] = bus_wdata_i;
                    if (grp == GRP_MASK)   st_d.mask[b*BANK_W +: BANK_W] = bus_wdata_i;
                end
            end
            for (int p = 0; p < NUM_PRIO_REG; p++) begin
                if (is_prio && prio_sel == 3'(p))
                    st_d.prio[p*BANK_W +: BANK_W] = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i[1:0] == 2'b00) begin
            if (bus_addr_i == OFF_VECTOR)
                bus_rdata_o = st_q.base + BANK_W'({st_q.vec_idx, 2'b00});
            if (bus_addr_i == OFF_BASE)
                bus_rdata_o = st_q.base;
            for (int b = 0; b < NUM_BANK; b++) begin
                if (bank_sel == 2'(b)) begin
                    case (grp)
                        GRP_IRQ_PEND: bus_rdata_o = st_q.pend[b*BANK_W +: BANK_W] & ~st_q.sel[b*BANK_W +: BANK_W];
                        GRP_FIQ_PEND: bus_rdata_o = st_q.pend[b*BANK_W +: BANK_W] &  st_q.sel[b*BANK_W +: BANK_W];
                        GRP_SELECT:   bus_rdata_o = st_q.sel [b*BANK_W +: BANK_W];
                        GRP_ENABLE:   bus_rdata_o = st_q.en  [b*BANK_W +: BANK_W];
                        GRP_MASK:     bus_rdata_o = st_q.mask[b*BANK_W +: BANK_W];
                        default: ;
                    endcase
                end
            end
            for (int p = 0; p < NUM_PRIO_REG; p++) begin
                if (is_prio && prio_sel == 3'(p))
                    bus_rdata_o = st_q.prio[p*BANK_W +: BANK_W];
            end
        end
    end

    assign irq_o = st_q.irq;
    assign fiq_o = st_q.fiq;
endmodule

// File: rtl/intc_sva.sv
module intc_sva
    import intc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic               fiq_o,
    input logic               bus_we_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [BANK_W-1:0]  bus_wdata_i,
    input logic [BANK_W-1:0]  src_lo,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] sel,
    input logic [IDX_W-1:0]   vec_idx
);
    localparam logic [NUM_SRC-1:0] NO_SRC0 = ~NUM_SRC'(1);
    logic [NUM_SRC-1:0] elig_irq, elig_fiq;
    assign elig_irq = pend & en & ~mask & ~sel & NO_SRC0;
    assign elig_fiq = pend & en & ~mask &  sel & NO_SRC0;

    a_r5_no_pend_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(en)) == '0);

    a_r3_src0_never_reported: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> vec_idx != '0);

    a_r3_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_idx == '0);

    a_r6_no_irq_without_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        $past(elig_irq == '0) |-> !irq_o);

    a_r8_fiq_needs_routed_line: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(elig_fiq != '0));

    a_r7_winner_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (($past(elig_irq) >> vec_idx) & NUM_SRC'(1)) != '0);

    a_r4_bank0_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == 8'h10 && bus_wdata_i == '1 && src_lo == '0
         && sel[BANK_W-1:0] == '0) |=> pend[BANK_W-1:0] == '0);
endmodule

bind intc_banked_top intc_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .src_lo      (src_i[31:0]),
    .pend        (st_q.pend),
    .en          (st_q.en),
    .mask        (st_q.mask),
    .sel         (st_q.sel),
    .vec_idx     (st_q.vec_idx)
);

// File: tb/intc_banked_top_tb.sv
module intc_banked_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intc_banked_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk); src[n] = 1'b1;
        @(negedge clk); src[n] = 1'b0;
    endtask

    task automatic tick(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic scrub();
        for (int b = 0; b < 3; b++) begin
            wr(8'h30 + 8'(4*b), '0);
            wr(8'h50 + 8'(4*b), '0);
            wr(8'h10 + 8'(4*b), '1);
        end
        for (int p = 0; p < 6; p++) wr(8'h80 + 8'(4*p), '0);
        wr(8'h04, '0);
        tick(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq_o", 32'(irq), 0);
        check("R1 fiq_o", 32'(fiq), 0);
        rd(8'h00, v); check("R1 vector", v, 0);
        rd(8'h44, v); check("R1 enable", v, 0);
        rd(8'h8c, v); check("R1 priority", v, 0);
        rd(8'h10, v); check("R1 pending", v, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(8'h44, 32'ha5a5_0001); rd(8'h44, v); check("R12 enable rb", v, 32'ha5a5_0001);
        wr(8'h58, 32'h0f0f_f0f0); rd(8'h58, v); check("R12 mask rb", v, 32'h0f0f_f0f0);
        wr(8'h94, 32'h1234_5678); rd(8'h94, v); check("R12 prio rb", v, 32'h1234_5678);
        wr(8'h04, 32'h0000_1000); rd(8'h04, v); check("R11 base rb", v, 32'h0000_1000);
        rd(8'h0c, v); check("R12 unmapped", v, 0);
        wr(8'h44, '0); wr(8'h58, '0); wr(8'h94, '0); wr(8'h04, '0);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        wr(8'h40, '1);
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk); src[5] = 1'b0;
        rd(8'h10, v); check("R2 pending bit 5", v, 32'h20);
        check("R10 irq not yet", 32'(irq), 0);
        tick(1);
        check("R10 irq after 2 edges", 32'(irq), 1);
        rd(8'h00, v); check("R3 vector 5", v, 32'd20);
        wr(8'h10, 32'h20);
        rd(8'h10, v); check("R4 cleared", v, 0);
        tick(1);
        check("R3 irq drops", 32'(irq), 0);
        rd(8'h00, v); check("R3 idle vector", v, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(3); pulse(7);
        wr(8'h10, 32'h8);
        rd(8'h10, v); check("R4 partial clear", v, 32'h80);
        wr(8'h10, 32'h0);
        rd(8'h10, v); check("R4 zero write", v, 32'h80);
        scrub();
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(8'h48, '0);
        pulse(70);
        rd(8'h18, v); check("R5 disabled no pend", v, 0);
        tick(1); check("R5 no irq", 32'(irq), 0);
        wr(8'h44, 32'h100);
        pulse(40);
        wr(8'h44, 32'h0);
        rd(8'h14, v); check("R5 pend kept", v, 32'h100);
        wr(8'h14, '1);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(8'h50, 32'h400);
        pulse(10); tick(1);
        check("R6 masked irq", 32'(irq), 0);
        rd(8'h10, v); check("R6 pend kept", v, 32'h400);
        wr(8'h50, 32'h0); tick(1);
        check("R6 unmasked irq", 32'(irq), 1);
        rd(8'h00, v); check("R6 vector", v, 32'd40);
        scrub();
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(8'h44, '1);
        wr(8'h80, 32'h1 << 20);               // line 10 -> 1
        wr(8'h8c, (32'h2 << 4) | (32'h2 << 24)); // line 50 -> 2, line 60 -> 2
        @(negedge clk); src[10] = 1'b1; src[50] = 1'b1; src[60] = 1'b1;
        @(negedge clk); src = '0;
        tick(1);
        rd(8'h00, v); check("R7 tie lowest", v, 32'(50*4));
        wr(8'h8c, (32'h2 << 4) | (32'h3 << 24));
        tick(1);
        rd(8'h00, v); check("R7 higher wins", v, 32'(60*4));
        scrub(); wr(8'h44, '0);
    endtask

    task automatic t_fiq();
        logic [31:0] v;
        wr(8'h44, '1);
        wr(8'h34, 32'h2);
        pulse(33); tick(1);
        check("R8 fiq high", 32'(fiq), 1);
        check("R8 irq low", 32'(irq), 0);
        rd(8'h24, v); check("R8 fast pend", v, 32'h2);
        rd(8'h14, v); check("R8 normal pend", v, 0);
        wr(8'h24, 32'h2); tick(1);
        check("R8 fiq cleared", 32'(fiq), 0);
        scrub(); wr(8'h44, '0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk); src[12] = 1'b1;
        wr(8'h10, 32'h1000);
        rd(8'h10, v); check("R9 repend", v, 32'h1000);
        src[12] = 1'b0;
        wr(8'h10, 32'h1000);
        rd(8'h10, v); check("R9 cleared", v, 0);
    endtask

    task automatic t_base();
        logic [31:0] v;
        wr(8'h04, 32'h4000_0000);
        pulse(0); tick(1);
        check("R3 line0 no irq", 32'(irq), 0);
        rd(8'h00, v); check("R3 base only", v, 32'h4000_0000);
        pulse(9); tick(1);
        rd(8'h00, v); check("R11 base plus idx", v, 32'h4000_0024);
        scrub();
    endtask

    initial begin
        tick(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_readback();
        t_latch();
        t_w1c();
        t_disable();
        t_mask();
        t_level();
        wr(8'h40, '0);
        t_prio();
        t_fiq();
        wr(8'h40, '1);
        t_base();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule